// File: doc/BRIEF.md
# Banked GPIO Port with Per-Pin Interrupts

This block is a general-purpose I/O port of 24 pins, grouped into three banks of eight, that a host controls through a byte-wide register bus. Each pin has a direction and a drive or pull style. Its output level changes only through write-1 set and write-1 clear strobes. Each pin also has a read-only view of its synchronized input level. The pad ring is outside the block: it receives output level, output enable, pull enable and pull direction per pin, and it returns the raw pin level.

Any pin can raise an interrupt, either on a level or on an edge, with a selectable polarity. A detected event latches into a per-pin pending bit. That bit stays set until the host writes 1 to the matching acknowledge bit. The block ORs all pending bits into one request line for a global interrupt aggregator.

The host writes with `bus_we` and reads combinationally from `bus_rdata` at any time. The address splits into a function code in bits [7:2] and a bank index in bits [1:0].

Top module: `gpio_port`

## Requirements
- R1: After reset every configuration field, every output level and every pending bit is 0, so `pin_out`, `pin_oe`, `pin_pull_en`, `pin_pull_up` and `irq_any` are all 0.
- R2: Function codes 0 (direction, 1 = output), 1 (style: open-drain for outputs or pull enable for inputs), 2 (pull direction, 1 = up), 6 (interrupt enable), 7 (event kind, 1 = edge) and 8 (polarity, 1 = high/rising) read back what was written. Per pin, `pin_oe` = direction AND (NOT style OR NOT level), `pin_pull_en` = NOT direction AND style, and `pin_pull_up` = the pull-direction bit.
- R3: A write to function 3 sets each output level whose data bit is 1. A write to function 4 clears each output level whose data bit is 1. Zero bits and other banks keep their level, and the new level shows on `pin_out` after the write's clock edge.
- R4: Function 5 reads the pin level after a two-flop synchronizer. A change on `pin_in` is readable two clock edges later and is not readable after one.
- R5: An enabled pin in level mode (event kind 0) sets its pending bit while its synchronized level equals the polarity bit (0 = low, 1 = high). The pending bit is readable at function 9 three edges after the input change and is not readable after two.
- R6: An enabled pin in edge mode sets its pending bit on a rising edge when polarity is 1 and on a falling edge when polarity is 0. The opposite edge leaves it clear.
- R7: A pin whose enable bit is 0 never sets its pending bit, whatever its level or edges.
- R8: Writing 1 to a bit of function 10 clears that pending bit, and zero bits leave pending bits as they are. A level-mode pin whose level is still active sets again on the next edge after the acknowledge.
- R9: `irq_any` is 1 exactly when at least one pending bit is set, and it falls only after an acknowledge write.
- R10: Addresses with bank index 3, and function codes above 10, read as 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Function code [7:2], bank index [1:0] |
| bus_wdata | input | 8 | Write data for one bank |
| bus_rdata | output | 8 | Combinational read data |
| pin_in | input | 24 | Raw pin levels from the pads |
| pin_out | output | 24 | Output level per pin |
| pin_oe | output | 24 | Output drive enable per pin |
| pin_pull_en | output | 24 | Pull resistor enable per pin |
| pin_pull_up | output | 24 | Pull direction per pin, 1 = up |
| irq_any | output | 1 | OR of all pending bits |

## Verification
The bench builds the block with its default parameters: three banks of eight pins and a two-stage synchronizer. These values bring the full bank index range within reach, including the unused fourth bank code, so decode holes can be probed. They also make the exact two- and three-edge latencies observable from the register bus. Scenarios exercise level and edge detection in both polarities on different banks, acknowledge while a level is still active, and set/clear masks that overlap earlier contents.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
   localparam int unsigned SEL_W = 2;
   localparam int unsigned FN_W  = 6;

   typedef enum logic [FN_W-1:0] {
      FN_DIR   = 6'd0,
      FN_STYLE = 6'd1,
      FN_PULL  = 6'd2,
      FN_SET   = 6'd3,
      FN_CLR   = 6'd4,
      FN_STATE = 6'd5,
      FN_IEN   = 6'd6,
      FN_IKIND = 6'd7,
      FN_IPOL  = 6'd8,
      FN_PEND  = 6'd9,
      FN_ACK   = 6'd10
   } gpio_fn_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int unsigned W      = 24,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) chain[s] <= '0;
      end else begin
         chain[0] <= d;
         for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit #(
   parameter int unsigned W = 24
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl_now,
   input  logic [W-1:0] en,
   input  logic [W-1:0] kind_edge,
   input  logic [W-1:0] pol,
   input  logic [W-1:0] ack,
   output logic [W-1:0] pend
);
   logic [W-1:0] lvl_prev;
   logic [W-1:0] pend_q;
   logic [W-1:0] hit_edge;
   logic [W-1:0] hit_lvl;

   // one detector per pin; the polarity bit names the active value
   for (genvar p = 0; p < W; p++) begin : g_pin
      logic active;
      assign active      = ~(lvl_now[p] ^ pol[p]);
      assign hit_edge[p] = en[p] & kind_edge[p] & (lvl_now[p] ^ lvl_prev[p]) & active;
      assign hit_lvl[p]  = en[p] & ~kind_edge[p] & active;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_prev <= '0;
         pend_q   <= '0;
      end else begin
         lvl_prev <= lvl_now;
         // edges survive a coincident acknowledge; levels re-arm one cycle later
         pend_q   <= (pend_q & ~ack) | hit_edge | (hit_lvl & ~ack);
      end
   end

   assign pend = pend_q;
endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
   import gpio_pkg::*;
#(
   parameter int unsigned NUM_BANKS = 3,
   parameter int unsigned BANK_W    = 8,
   localparam int unsigned NPINS    = NUM_BANKS * BANK_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [7:0]        bus_addr,
   input  logic [BANK_W-1:0] bus_wdata,
   output logic [BANK_W-1:0] bus_rdata,
   input  logic [NPINS-1:0]  state,
   input  logic [NPINS-1:0]  pend,
   output logic [NPINS-1:0]  dir_q,
   output logic [NPINS-1:0]  style_q,
   output logic [NPINS-1:0]  pull_q,
   output logic [NPINS-1:0]  ien_q,
   output logic [NPINS-1:0]  ikind_q,
   output logic [NPINS-1:0]  ipol_q,
   output logic [NPINS-1:0]  lvl_q,
   output logic [NPINS-1:0]  ack
);
   logic [FN_W-1:0]  fn_f;
   logic [SEL_W-1:0] bank_f;
   logic [31:0]      bank_ix;
   logic             bank_ok;

   assign {fn_f, bank_f} = bus_addr;
   assign bank_ix = 32'(bank_f);
   assign bank_ok = bank_ix < NUM_BANKS;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q   <= '0;
         style_q <= '0;
         pull_q  <= '0;
         ien_q   <= '0;
         ikind_q <= '0;
         ipol_q  <= '0;
         lvl_q   <= '0;
      end else if (bus_we && bank_ok) begin
         case (fn_f)
            FN_DIR:   dir_q  [bank_ix*BANK_W +: BANK_W] <= bus_wdata;
            FN_STYLE: style_q[bank_ix*BANK_W +: BANK_W] <= bus_wdata;
            FN_PULL:  pull_q [bank_ix*BANK_W +: BANK_W] <= bus_wdata;
            FN_IEN:   ien_q  [bank_ix*BANK_W +: BANK_W] <= bus_wdata;
            FN_IKIND: ikind_q[bank_ix*BANK_W +: BANK_W] <= bus_wdata;
            FN_IPOL:  ipol_q [bank_ix*BANK_W +: BANK_W] <= bus_wdata;
            FN_SET:   lvl_q  [bank_ix*BANK_W +: BANK_W] <=
                         lvl_q[bank_ix*BANK_W +: BANK_W] | bus_wdata;
            FN_CLR:   lvl_q  [bank_ix*BANK_W +: BANK_W] <=
                         lvl_q[bank_ix*BANK_W +: BANK_W] & ~bus_wdata;
            default: ;
         endcase
      end
   end

   always_comb begin
      ack = '0;
      if (bus_we && bank_ok && fn_f == FN_ACK)
         ack[bank_ix*BANK_W +: BANK_W] = bus_wdata;
   end

   always_comb begin
      bus_rdata = '0;
      if (bank_ok) begin
         case (fn_f)
            FN_DIR:   bus_rdata = dir_q  [bank_ix*BANK_W +: BANK_W];
            FN_STYLE: bus_rdata = style_q[bank_ix*BANK_W +: BANK_W];
            FN_PULL:  bus_rdata = pull_q [bank_ix*BANK_W +: BANK_W];
            FN_IEN:   bus_rdata = ien_q  [bank_ix*BANK_W +: BANK_W];
            FN_IKIND: bus_rdata = ikind_q[bank_ix*BANK_W +: BANK_W];
            FN_IPOL:  bus_rdata = ipol_q [bank_ix*BANK_W +: BANK_W];
            FN_STATE: bus_rdata = state  [bank_ix*BANK_W +: BANK_W];
            FN_PEND:  bus_rdata = pend   [bank_ix*BANK_W +: BANK_W];
            default:  bus_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
   import gpio_pkg::*;
#(
   parameter int unsigned NUM_BANKS   = 3,
   parameter int unsigned BANK_W      = 8,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned NPINS      = NUM_BANKS * BANK_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [7:0]        bus_addr,
   input  logic [BANK_W-1:0] bus_wdata,
   output logic [BANK_W-1:0] bus_rdata,
   input  logic [NPINS-1:0]  pin_in,
   output logic [NPINS-1:0]  pin_out,
   output logic [NPINS-1:0]  pin_oe,
   output logic [NPINS-1:0]  pin_pull_en,
   output logic [NPINS-1:0]  pin_pull_up,
   output logic              irq_any
);
   if (NUM_BANKS < 1 || NUM_BANKS > (1 << SEL_W)) begin : g_bad_banks
      $error("gpio_port: NUM_BANKS must fit the bank index field");
   end
   if (BANK_W < 1) begin : g_bad_width
      $error("gpio_port: BANK_W must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("gpio_port: SYNC_STAGES must be at least 2");
   end

   logic [NPINS-1:0] lvl_sync;
   logic [NPINS-1:0] dir_q, style_q, pull_q, ien_q, ikind_q, ipol_q, lvl_q;
   logic [NPINS-1:0] ack, pend;

   gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (lvl_sync)
   );

   gpio_cfg_regs #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) i_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .state     (lvl_sync),
      .pend      (pend),
      .dir_q     (dir_q),
      .style_q   (style_q),
      .pull_q    (pull_q),
      .ien_q     (ien_q),
      .ikind_q   (ikind_q),
      .ipol_q    (ipol_q),
      .lvl_q     (lvl_q),
      .ack       (ack)
   );

   gpio_irq_unit #(.W(NPINS)) i_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .lvl_now   (lvl_sync),
      .en        (ien_q),
      .kind_edge (ikind_q),
      .pol       (ipol_q),
      .ack       (ack),
      .pend      (pend)
   );

   // open-drain outputs drive only their low level
   assign pin_out     = lvl_q;
   assign pin_oe      = dir_q & (~style_q | ~lvl_q);
   assign pin_pull_en = ~dir_q & style_q;
   assign pin_pull_up = pull_q;
   assign irq_any     = |pend;
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
   import gpio_pkg::*;
#(
   parameter int unsigned BANK_W = 8,
   parameter int unsigned NPINS  = 24
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_we,
   input logic [7:0]        bus_addr,
   input logic [BANK_W-1:0] bus_wdata,
   input logic [NPINS-1:0]  pin_out,
   input logic [NPINS-1:0]  pin_oe,
   input logic [NPINS-1:0]  pin_pull_en,
   input logic              irq_any
);
   logic [FN_W-1:0]  c_fn;
   logic [SEL_W-1:0] c_bank;
   assign {c_fn, c_bank} = bus_addr;

   assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> (irq_any == 1'b0 && pin_oe == '0));

   assert_no_drive_with_pull_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_oe & pin_pull_en) == '0);

   assert_set_bank0_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && c_fn == FN_SET && c_bank == '0) |=>
         pin_out[BANK_W-1:0] == ($past(pin_out[BANK_W-1:0]) | $past(bus_wdata)));

   assert_clr_bank0_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && c_fn == FN_CLR && c_bank == '0) |=>
         pin_out[BANK_W-1:0] == ($past(pin_out[BANK_W-1:0]) & ~$past(bus_wdata)));

   assert_irq_falls_on_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_any) |-> $past(bus_we && c_fn == FN_ACK));
endmodule

bind gpio_port gpio_port_chk #(.BANK_W(BANK_W), .NPINS(NPINS)) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_we      (bus_we),
   .bus_addr    (bus_addr),
   .bus_wdata   (bus_wdata),
   .pin_out     (pin_out),
   .pin_oe      (pin_oe),
   .pin_pull_en (pin_pull_en),
   .irq_any     (irq_any)
);

// File: tb/test_gpio_port.sv
module test_gpio_port;
   import gpio_pkg::*;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic [23:0] pin_in = '0;
   logic [23:0] pin_out, pin_oe, pin_pull_en, pin_pull_up;
   logic        irq_any;
   int n_vec = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gpio_port i_gpio_port (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe), .pin_pull_en(pin_pull_en),
      .pin_pull_up(pin_pull_up), .irq_any(irq_any)
   );

   function automatic logic [7:0] ad(input logic [5:0] fn, input logic [1:0] bk);
      return {fn, bk};
   endfunction

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd_chk(input string req, input string what, input logic [7:0] a, input logic [7:0] exp);
      bus_addr = a;
      #1;
      chk(req, what, {24'b0, bus_rdata}, {24'b0, exp});
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset;
      for (int b = 0; b < 3; b++) begin
         rd_chk("R1", "dir", ad(FN_DIR, 2'(b)), 8'h00);
         rd_chk("R1", "ien", ad(FN_IEN, 2'(b)), 8'h00);
         rd_chk("R1", "pend", ad(FN_PEND, 2'(b)), 8'h00);
      end
      chk("R1", "pin_out", pin_out, 24'h0);
      chk("R1", "pin_oe", pin_oe, 24'h0);
      chk("R1", "pull_en", pin_pull_en, 24'h0);
      chk("R1", "pull_up", pin_pull_up, 24'h0);
      chk("R1", "irq_any", irq_any, 1'b0);
   endtask

   task automatic t_config;
      wr(ad(FN_DIR, 1), 8'hA5);
      wr(ad(FN_STYLE, 1), 8'h0F);
      wr(ad(FN_PULL, 1), 8'h3C);
      wr(ad(FN_IKIND, 2), 8'h5A);
      wr(ad(FN_IPOL, 2), 8'hC3);
      rd_chk("R2", "dir b1", ad(FN_DIR, 1), 8'hA5);
      rd_chk("R2", "style b1", ad(FN_STYLE, 1), 8'h0F);
      rd_chk("R2", "pull b1", ad(FN_PULL, 1), 8'h3C);
      rd_chk("R2", "kind b2", ad(FN_IKIND, 2), 8'h5A);
      rd_chk("R2", "pol b2", ad(FN_IPOL, 2), 8'hC3);
      chk("R2", "oe b1 low", {24'b0, pin_oe[15:8]}, 32'hA5);
      chk("R2", "pull_en b1", {24'b0, pin_pull_en[15:8]}, 32'h0A);
      chk("R2", "pull_up b1", {24'b0, pin_pull_up[15:8]}, 32'h3C);
      wr(ad(FN_SET, 1), 8'hFF);
      chk("R2", "oe b1 high (open-drain releases)", {24'b0, pin_oe[15:8]}, 32'hA0);
      chk("R3", "out b1", {24'b0, pin_out[15:8]}, 32'hFF);
      wr(ad(FN_IKIND, 2), 8'h00);
      wr(ad(FN_IPOL, 2), 8'h00);
   endtask

   task automatic t_setclr;
      wr(ad(FN_SET, 2), 8'h0F);
      chk("R3", "set b2", pin_out, 24'h0FFF00);
      wr(ad(FN_SET, 2), 8'h30);
      chk("R3", "set keeps zeros", pin_out, 24'h3FFF00);
      wr(ad(FN_CLR, 2), 8'h05);
      chk("R3", "clr b2", pin_out, 24'h3AFF00);
      wr(ad(FN_CLR, 2), 8'h00);
      chk("R3", "clr zero no effect", pin_out, 24'h3AFF00);
      wr(ad(FN_SET, 0), 8'h81);
      wr(ad(FN_CLR, 0), 8'h01);
      chk("R3", "set/clr b0", pin_out, 24'h3AFF80);
      wr(ad(FN_CLR, 0), 8'hFF);
   endtask

   task automatic t_state;
      @(negedge clk);
      pin_in = 24'h123456;
      cyc(1);
      rd_chk("R4", "state after one edge", ad(FN_STATE, 0), 8'h00);
      cyc(1);
      rd_chk("R4", "state b0", ad(FN_STATE, 0), 8'h56);
      rd_chk("R4", "state b1", ad(FN_STATE, 1), 8'h34);
      rd_chk("R4", "state b2", ad(FN_STATE, 2), 8'h12);
      pin_in = 24'h0;
      cyc(4);
   endtask

   task automatic t_level;
      wr(ad(FN_IPOL, 0), 8'h01);
      wr(ad(FN_IEN, 0), 8'h03);
      cyc(1);
      rd_chk("R5", "low-level pin1 pending", ad(FN_PEND, 0), 8'h02);
      pin_in[0] = 1'b1;
      cyc(2);
      rd_chk("R5", "high-level not yet", ad(FN_PEND, 0), 8'h02);
      cyc(1);
      rd_chk("R5", "high-level pin0 pending", ad(FN_PEND, 0), 8'h03);
      chk("R9", "irq_any set", irq_any, 1'b1);
   endtask

   task automatic t_ack;
      wr(ad(FN_ACK, 0), 8'h00);
      rd_chk("R8", "ack zero no effect", ad(FN_PEND, 0), 8'h03);
      wr(ad(FN_ACK, 0), 8'h01);
      rd_chk("R8", "ack clears pin0", ad(FN_PEND, 0), 8'h02);
      cyc(1);
      rd_chk("R8", "active level re-sets", ad(FN_PEND, 0), 8'h03);
      pin_in[1:0] = 2'b10;
      cyc(3);
      wr(ad(FN_ACK, 0), 8'h03);
      rd_chk("R8", "ack both", ad(FN_PEND, 0), 8'h00);
      chk("R9", "irq_any clear", irq_any, 1'b0);
      cyc(2);
      rd_chk("R8", "inactive stays clear", ad(FN_PEND, 0), 8'h00);
      wr(ad(FN_IEN, 0), 8'h00);
   endtask

   task automatic t_edge;
      pin_in = 24'h0;
      cyc(3);
      wr(ad(FN_IKIND, 1), 8'h03);
      wr(ad(FN_IPOL, 1), 8'h01);
      wr(ad(FN_IEN, 1), 8'h03);
      cyc(2);
      rd_chk("R6", "edge no event", ad(FN_PEND, 1), 8'h00);
      pin_in[9:8] = 2'b11;
      cyc(3);
      rd_chk("R6", "rise: pin8 only", ad(FN_PEND, 1), 8'h01);
      wr(ad(FN_ACK, 1), 8'h01);
      pin_in[9:8] = 2'b00;
      cyc(3);
      rd_chk("R6", "fall: pin9 only", ad(FN_PEND, 1), 8'h02);
      chk("R9", "irq_any one bit", irq_any, 1'b1);
      cyc(2);
      rd_chk("R6", "edge holds, no repeat", ad(FN_PEND, 1), 8'h02);
      wr(ad(FN_ACK, 1), 8'h02);
      cyc(2);
      rd_chk("R6", "edge cleared stays clear", ad(FN_PEND, 1), 8'h00);
      chk("R9", "irq_any after ack", irq_any, 1'b0);
   endtask

   task automatic t_disabled;
      wr(ad(FN_IPOL, 2), 8'h01);
      pin_in[16] = 1'b1;
      cyc(4);
      pin_in[16] = 1'b0;
      cyc(4);
      rd_chk("R7", "disabled pin no pending", ad(FN_PEND, 2), 8'h00);
      chk("R7", "irq_any quiet", irq_any, 1'b0);
   endtask

   task automatic t_unmapped;
      wr(ad(FN_DIR, 3), 8'hFF);
      rd_chk("R10", "bank3 reads 0", ad(FN_DIR, 3), 8'h00);
      rd_chk("R10", "dir b0 untouched", ad(FN_DIR, 0), 8'h00);
      rd_chk("R10", "dir b1 untouched", ad(FN_DIR, 1), 8'hA5);
      rd_chk("R10", "dir b2 untouched", ad(FN_DIR, 2), 8'h00);
      wr(ad(6'd11, 0), 8'hFF);
      wr(ad(6'd63, 2), 8'hFF);
      rd_chk("R10", "fn 11 reads 0", ad(6'd11, 0), 8'h00);
      rd_chk("R10", "fn 63 reads 0", ad(6'd63, 2), 8'h00);
      chk("R10", "pins untouched", pin_out, 24'h3AFF00);
      chk("R10", "oe untouched", pin_oe, 24'h00A000);
   endtask

   initial begin
      #(CLK_PERIOD * 50000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      cyc(3);
      t_reset();
      rst_n = 1'b1;
      cyc(2);
      t_config();
      t_setclr();
      t_state();
      t_level();
      t_ack();
      t_edge();
      t_disabled();
      t_unmapped();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule